// File: doc/BRIEF.md
# Byte-wide host to memory-mapped bus bridge

This block gives an external processor with only an 8-bit parallel port access to an on-chip memory-mapped bus, for example to load a soft processor's program image into RAM or to dump memory while that processor keeps running. The host reaches eight byte registers through a 3-bit select. It builds a 32-bit data word and a 24-bit word address one byte at a time, then writes a command byte. That byte either launches a single 32-bit bus transfer, or sets or clears a reset line to the soft processor, or both.

Bus cycles may take any number of clocks, because the slave can stretch them with a wait request. The host therefore polls a busy flag in the status register rather than assuming the transfer is done. Read data returns into the same four data registers the host uses for write data. All host strobes are sampled in the bridge clock domain.

Top module: `hostbus_bridge`

## Requirements
- R1: Register select 0..3 are data bytes (select 0 holds bits 7:0), select 4..6 are address bytes (select 4 holds bits 7:0) and select 7 is command/status. A host write to select 0..6 stores the byte at any time. A host read returns the selected byte on `host_rdata` from the clock after the read strobe is sampled.
- R2: After synchronous reset, all data and address registers read 0, status reads 0, `cpu_reset` is 1 and neither bus strobe is high.
- R3: A command byte with bits 1:0 = 10 starts exactly one write. `bus_write` rises in the cycle after the command strobe, carrying the 24-bit address, the 32-bit data and `bus_byteen` = 1111.
- R4: A command byte with bits 1:0 = 01 starts exactly one read with `bus_byteen` = 1111. The word present on `bus_rdata` in the completing clock is stored in the four data registers no later than busy clears.
- R5: While `bus_waitreq` is high, the bridge holds address, strobe and write data stable. It completes on the first clock with `bus_waitreq` low, so a transfer with W wait clocks keeps its strobe high for W+1 cycles, and the strobe drops in the following cycle.
- R6: Status bit 7 (busy) reads 1 from the clock after a command is accepted until the completing clock. The other status bits read 0.
- R7: A command byte written while busy is ignored entirely. It starts no transfer and does not change `cpu_reset`.
- R8: Data and address are sampled when a command is accepted. Host writes to them during the transfer are stored, but the transfer in flight does not use them.
- R9: Command bit 2 asserts `cpu_reset` and bit 3 releases it. If both are set, assert wins. A command with neither bit set leaves `cpu_reset` at its level. Opcodes 00 and 11 start no transfer.
- R10: Bus reads and writes work the same whether `cpu_reset` is high or low, and they never change `cpu_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Host register select |
| host_cs | input | 1 | Host chip select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| bus_addr | output | 24 | Bus word address |
| bus_read | output | 1 | Bus read strobe |
| bus_write | output | 1 | Bus write strobe |
| bus_byteen | output | 4 | Bus byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_waitreq | input | 1 | Slave wait request |
| cpu_reset | output | 1 | Reset to the soft processor |

## Verification
A command sampled at clock edge N raises its bus strobe and the busy flag just after N. With W wait clocks, the transfer completes at edge N+W+1, and read data and the cleared busy flag are visible just after that edge. A host read sampled at an edge shows its byte on `host_rdata` just after that edge. The bench drives strobes at falling edges and reads results at the following falling edge, so every value is taken half a period after the edge that produced it. The bus model counts strobe-high cycles per transfer to check the W+1 length and flags any change of address or data in mid-transfer.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  localparam logic [SEL_W-1:0] SEL_DATA0 = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR0 = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CMD   = 3'd7;

  localparam int BIT_RST_ON  = 2;
  localparam int BIT_RST_OFF = 3;
  localparam int BIT_BUSY    = 7;
endpackage

// File: rtl/hb_host_regs.sv
module hb_host_regs
  import hb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic              host_cs,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] data_word,
  output logic [ADDR_W-1:0] addr_word,
  output logic              cmd_go,
  output op_e               cmd_op,
  output logic              cmd_rst_on,
  output logic              cmd_rst_off
);
  localparam int DBYTES = DATA_W / 8;
  localparam int ABYTES = (ADDR_W + 7) / 8;

  logic [7:0] dreg [DBYTES];
  logic [7:0] areg [ABYTES];
  logic [ABYTES*8-1:0] abus;
  logic       wr_hit;
  logic [7:0] rd_mux;

  assign wr_hit      = host_cs && host_wr;
  assign cmd_go      = wr_hit && (host_sel == SEL_CMD) && !busy;
  assign cmd_op      = op_e'(host_wdata[1:0]);
  assign cmd_rst_on  = host_wdata[BIT_RST_ON];
  assign cmd_rst_off = host_wdata[BIT_RST_OFF];

  for (genvar i = 0; i < DBYTES; i++) begin : g_data
    always_ff @(posedge clk) begin
      if (rst)
        dreg[i] <= '0;
      else if (rd_done)
        dreg[i] <= rd_word[8*i +: 8];
      else if (wr_hit && host_sel == SEL_DATA0 + SEL_W'(i))
        dreg[i] <= host_wdata;
    end
    assign data_word[8*i +: 8] = dreg[i];
  end

  for (genvar j = 0; j < ABYTES; j++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst)
        areg[j] <= '0;
      else if (wr_hit && host_sel == SEL_ADDR0 + SEL_W'(j))
        areg[j] <= host_wdata;
    end
    assign abus[8*j +: 8] = areg[j];
  end

  assign addr_word = abus[ADDR_W-1:0];

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < DBYTES; k++)
      if (host_sel == SEL_DATA0 + SEL_W'(k)) rd_mux = dreg[k];
    for (int k = 0; k < ABYTES; k++)
      if (host_sel == SEL_ADDR0 + SEL_W'(k)) rd_mux = areg[k];
    if (host_sel == SEL_CMD) begin
      rd_mux = '0;
      rd_mux[BIT_BUSY] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (host_cs && host_rd)
      host_rdata <= rd_mux;
  end
endmodule

// File: rtl/hb_bus_master.sv
module hb_bus_master
  import hb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  op_e                 op,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [DATA_W-1:0]   data_in,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_read,
  output logic                bus_write,
  output logic [DATA_W/8-1:0] bus_byteen,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_waitreq,
  output logic                busy,
  output logic                rd_done,
  output logic [DATA_W-1:0]   rd_word
);
  typedef enum logic {ST_IDLE, ST_XFER} state_e;
  state_e state;
  logic   start_rd;
  logic   start_wr;
  logic   finish;

  assign start_rd = go && (op == OP_READ);
  assign start_wr = go && (op == OP_WRITE);
  assign finish   = (state == ST_XFER) && !bus_waitreq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_read  <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_rd || start_wr) begin
            state     <= ST_XFER;
            bus_read  <= start_rd;
            bus_write <= start_wr;
            bus_addr  <= addr_in;
            bus_wdata <= data_in;
          end
        end
        ST_XFER: begin
          if (finish) begin
            state     <= ST_IDLE;
            bus_read  <= 1'b0;
            bus_write <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state == ST_XFER);
  assign bus_byteen = {(DATA_W/8){busy}};
  assign rd_done    = finish && bus_read;
  assign rd_word    = bus_rdata;
endmodule

// File: rtl/hb_reset_ctl.sv
module hb_reset_ctl (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic set_req,
  input  logic clr_req,
  output logic cpu_reset
);
  always_ff @(posedge clk) begin
    if (rst)
      cpu_reset <= 1'b1;
    else if (go && set_req)
      cpu_reset <= 1'b1;
    else if (go && clr_req)
      cpu_reset <= 1'b0;
  end
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
  import hb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    host_sel,
  input  logic                host_cs,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_read,
  output logic                bus_write,
  output logic [DATA_W/8-1:0] bus_byteen,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_waitreq,
  output logic                cpu_reset
);
  logic              busy;
  logic              rd_done;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] data_word;
  logic [ADDR_W-1:0] addr_word;
  logic              cmd_go;
  op_e               cmd_op;
  logic              cmd_rst_on;
  logic              cmd_rst_off;

  hb_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .rd_done(rd_done), .rd_word(rd_word),
    .data_word(data_word), .addr_word(addr_word),
    .cmd_go(cmd_go), .cmd_op(cmd_op),
    .cmd_rst_on(cmd_rst_on), .cmd_rst_off(cmd_rst_off)
  );

  hb_bus_master #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_master (
    .clk(clk), .rst(rst),
    .go(cmd_go), .op(cmd_op), .addr_in(addr_word), .data_in(data_word),
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_write(bus_write),
    .bus_byteen(bus_byteen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_waitreq(bus_waitreq),
    .busy(busy), .rd_done(rd_done), .rd_word(rd_word)
  );

  hb_reset_ctl u_rstctl (
    .clk(clk), .rst(rst), .go(cmd_go),
    .set_req(cmd_rst_on), .clr_req(cmd_rst_off), .cpu_reset(cpu_reset)
  );
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          host_sel,
  input logic                host_cs,
  input logic                host_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_read,
  input logic                bus_write,
  input logic [DATA_W/8-1:0] bus_byteen,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_waitreq,
  input logic                cpu_reset
);
  logic active;
  logic cmd_wr;
  assign active = bus_read || bus_write;
  assign cmd_wr = host_cs && host_wr && (host_sel == 3'd7);

  // R2
  rst_state_chk: assert property (@(posedge clk) $past(rst) |-> (cpu_reset && !active));

  // R3
  byteen_full_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (bus_byteen == '1));

  // R3
  no_spurious_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !cmd_wr) |=> !active);

  // R5
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (active && bus_waitreq) |=> ($stable(bus_addr) && $stable(bus_wdata)
                                 && $stable(bus_read) && $stable(bus_write)));

  // R5
  single_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !bus_waitreq) |=> !active);

  // R7
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (active && cmd_wr) |=> $stable(cpu_reset));

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_read, bus_write}));
endmodule

bind hostbus_bridge hb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_cs(host_cs), .host_wr(host_wr),
  .bus_addr(bus_addr), .bus_read(bus_read), .bus_write(bus_write),
  .bus_byteen(bus_byteen), .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq),
  .cpu_reset(cpu_reset)
);

// File: tb/hostbus_bridge_bench.sv
module hostbus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_sel = '0;
  logic        host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [23:0] bus_addr;
  logic        bus_read, bus_write, bus_waitreq;
  logic [3:0]  bus_byteen;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cpu_reset;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hostbus_bridge u_hostbus_bridge (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_cs(host_cs),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_write(bus_write), .bus_byteen(bus_byteen), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq), .cpu_reset(cpu_reset)
  );

  // bus slave model
  logic [31:0] mem [16];
  int          wait_n = 0, wcnt = 0, act_cyc = 0, last_act = 0, xfers = 0;
  logic [23:0] last_addr = '0, hold_addr = '0;
  logic [31:0] hold_wd = '0;
  bit          unstable = 0, bad_be = 0;

  assign bus_waitreq = (bus_read || bus_write) && (wcnt < wait_n);
  assign bus_rdata   = mem[bus_addr[3:0]];

  initial for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i;

  always @(posedge clk) begin
    if (bus_read || bus_write) begin
      if (act_cyc > 0 && (bus_addr != hold_addr || bus_wdata != hold_wd)) unstable <= 1;
      if (bus_byteen != 4'hF || (bus_read && bus_write)) bad_be <= 1;
      hold_addr <= bus_addr;
      hold_wd   <= bus_wdata;
      if (!bus_waitreq) begin
        xfers     <= xfers + 1;
        last_addr <= bus_addr;
        last_act  <= act_cyc + 1;
        act_cyc   <= 0;
        wcnt      <= 0;
        if (bus_write) mem[bus_addr[3:0]] <= bus_wdata;
      end else begin
        act_cyc <= act_cyc + 1;
        wcnt    <= wcnt + 1;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [2:0] sel, logic [7:0] val);
    @(negedge clk);
    host_sel = sel; host_wdata = val; host_cs = 1; host_wr = 1;
    @(negedge clk);
    host_cs = 0; host_wr = 0;
  endtask

  task automatic host_read(logic [2:0] sel, output logic [7:0] val);
    @(negedge clk);
    host_sel = sel; host_cs = 1; host_rd = 1;
    @(negedge clk);
    host_cs = 0; host_rd = 0;
    val = host_rdata;
  endtask

  task automatic set_word(logic [31:0] d, logic [23:0] a);
    for (int i = 0; i < 4; i++) host_write(3'(i), d[8*i +: 8]);
    for (int i = 0; i < 3; i++) host_write(3'(4 + i), a[8*i +: 8]);
  endtask

  task automatic wait_idle(string req);
    logic [7:0] s;
    int n = 0;
    do begin
      host_read(3'd7, s);
      n++;
    end while (s[7] && n < 200);
    chk(req, {24'h0, s}, 32'h0);
  endtask

  task automatic get_data(output logic [31:0] d);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      host_read(3'(i), b);
      d[8*i +: 8] = b;
    end
  endtask

  task automatic t_reset;
    logic [7:0] b;
    chk("R2 cpu_reset", {31'h0, cpu_reset}, 32'h1);
    chk("R2 strobes", {30'h0, bus_read, bus_write}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      host_read(3'(i), b);
      chk("R2 register", {24'h0, b}, 32'h0);
    end
  endtask

  task automatic t_regfile;
    logic [7:0] b;
    for (int i = 0; i < 7; i++) host_write(3'(i), 8'h31 + 8'(i * 17));
    for (int i = 0; i < 7; i++) begin
      host_read(3'(i), b);
      chk("R1 readback", {24'h0, b}, {24'h0, 8'h31 + 8'(i * 17)});
    end
    chk("R1 no transfer", xfers, 0);
  endtask

  task automatic t_write_word;
    logic [7:0] s;
    int x0 = xfers;
    wait_n = 2;
    set_word(32'h1122_3344, 24'h000002);
    host_write(3'd7, 8'h02);
    host_read(3'd7, s);
    chk("R6 busy set", {24'h0, s}, 32'h80);
    wait_idle("R6 busy clear");
    chk("R3 memory", mem[2], 32'h1122_3344);
    chk("R3 one transfer", xfers - x0, 1);
    chk("R3 address", {8'h0, last_addr}, 32'h2);
    chk("R5 strobe length", last_act, 3);
    chk("R5 stable", {31'h0, unstable}, 0);
    chk("R3 byte enables", {31'h0, bad_be}, 0);
  endtask

  task automatic t_read_word;
    logic [31:0] d;
    int x0 = xfers;
    wait_n = 3;
    mem[5] = 32'hCAFE_F00D;
    set_word(32'h0, 24'hABCDE5);
    host_write(3'd7, 8'h01);
    wait_idle("R4 busy clear");
    get_data(d);
    chk("R4 read data", d, 32'hCAFE_F00D);
    chk("R4 address", {8'h0, last_addr}, 32'h00AB_CDE5);
    chk("R4 one transfer", xfers - x0, 1);
    chk("R5 strobe length", last_act, 4);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] b;
    int x0;
    host_write(3'd7, 8'h08);
    chk("R9 release", {31'h0, cpu_reset}, 0);
    mem[8] = 32'h5555_0008;
    wait_n = 15;
    set_word(32'hA5A5_A5A5, 24'h000007);
    x0 = xfers;
    host_write(3'd7, 8'h02);
    host_write(3'd0, 8'h00);
    host_write(3'd4, 8'h08);
    host_write(3'd7, 8'h05);
    chk("R7 reset unchanged", {31'h0, cpu_reset}, 0);
    wait_idle("R7 busy clear");
    repeat (4) @(negedge clk);
    chk("R7 single transfer", xfers - x0, 1);
    chk("R8 sampled data", mem[7], 32'hA5A5_A5A5);
    chk("R8 other word", mem[8], 32'h5555_0008);
    chk("R7 reset still", {31'h0, cpu_reset}, 0);
    host_read(3'd0, b);
    chk("R8 late write stored", {24'h0, b}, 0);
    wait_n = 0;
  endtask

  task automatic t_reset_cmds;
    int x0 = xfers;
    host_write(3'd7, 8'h04);
    chk("R9 assert", {31'h0, cpu_reset}, 1);
    host_write(3'd7, 8'h00);
    chk("R9 hold high", {31'h0, cpu_reset}, 1);
    host_write(3'd7, 8'h08);
    chk("R9 release", {31'h0, cpu_reset}, 0);
    host_write(3'd7, 8'h03);
    chk("R9 hold low", {31'h0, cpu_reset}, 0);
    host_write(3'd7, 8'h0C);
    chk("R9 assert wins", {31'h0, cpu_reset}, 1);
    repeat (3) @(negedge clk);
    chk("R9 no transfer", xfers - x0, 0);
  endtask

  task automatic t_run_access;
    logic [31:0] d;
    host_write(3'd7, 8'h08);
    wait_n = 1;
    set_word(32'h0, 24'h000002);
    host_write(3'd7, 8'h01);
    wait_idle("R10 busy clear");
    get_data(d);
    chk("R10 read while running", d, 32'h1122_3344);
    chk("R10 reset kept low", {31'h0, cpu_reset}, 0);
    host_write(3'd7, 8'h04);
    set_word(32'h0BAD_F00D, 24'h000003);
    host_write(3'd7, 8'h02);
    wait_idle("R10 busy clear");
    chk("R10 write under reset", mem[3], 32'h0BAD_F00D);
    chk("R10 reset kept high", {31'h0, cpu_reset}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_regfile;
    t_write_word;
    t_read_word;
    t_busy_ignore;
    t_reset_cmds;
    t_run_access;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule